// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K bytes. The host offers one word at a time on a valid/ready handshake with an address, write data and a write flag. The controller turns each accepted request into a complete memory cycle. It drives the address, an active-low and an active-high chip enable, an active-low output enable and an active-low write strobe. Read data comes back on a registered port together with a one-cycle valid pulse.

The memory has one bidirectional data bus. The controller does not instantiate a tri-state buffer. It presents the outgoing byte, a driver-enable flag and an incoming byte, and the pad ring builds the bus from them. Every timing figure is a picosecond parameter. Each is converted at elaboration into a whole number of clock cycles, rounded up, so the same code serves any clock rate and speed grade.

Top module: `sram_cyc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no request made, all strobes are inactive (mem_en_n=1, mem_en=0, mem_oe_n=1, mem_we_n=1), mem_dq_oe=0, rd_valid=0 and req_ready=1.
- R2: A write moves mem_en_n low, mem_en high and mem_we_n low on the same clock edge. The byte stored at the address is req_wdata as captured at acceptance.
- R3: A read holds mem_en_n=0, mem_en=1, mem_oe_n=0 and mem_we_n=1. It returns on rd_data the byte stored at the requested address.
- R4: In a write, mem_we_n stays low for exactly 1 + WD clock cycles, where WD = max(DSU, WP-1, 1). mem_dq_oe rises one cycle after mem_we_n falls and falls on the edge that raises mem_we_n, so the bus is driven for exactly WD cycles.
- R5: mem_oe_n stays high for the whole of a write, and the controller never drives the bus while the memory drives it.
- R6: mem_addr never changes while mem_en_n is low, mem_en is high or mem_we_n is low. It changes only on the edge after acceptance, while every strobe is inactive.
- R7: rd_valid is high for exactly one cycle per read. rd_data holds its value until the next read completes.
- R8: req_ready is high only when every strobe is inactive. A request is taken when req_valid and req_ready are both high. The request inputs have no effect while req_ready is low.
- R9: The read strobes stay active for exactly ACC cycles before the data is captured. ACC, WP and DSU each equal the ceiling of their picosecond figure over CLK_PS, with a minimum of 1. With the defaults this gives ACC=2, WP=1 and DSU=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking new rd_data |
| mem_addr | output | 17 | Memory address |
| mem_en_n | output | 1 | Active-low chip enable |
| mem_en | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | 8 | Outgoing bus byte |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | 8 | Incoming bus byte |

## Verification
The bench's memory model returns a corrupted byte until the read strobes have been active for the full access count. A controller that captures one edge early therefore reads the wrong value. The model stores a byte only on the cycle that ends the write overlap, using the bus value seen while the driver was on. A controller that drops its driver before raising the strobe, or never drives the bus, loses data or is flagged. The model also flags any address change under an active strobe, any bus overlap, an output enable during a write, and a write strobe that falls after the enables. A request whose address and data are changed just after acceptance checks that busy-time inputs have no effect. Reads check the one-cycle valid pulse, and full-range addresses catch truncation of the upper address bits.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_RD_ACC   = 3'd2,
    ST_WR_OPEN  = 3'd3,
    ST_WR_DRIVE = 3'd4,
    ST_RECOV    = 3'd5
  } cyc_state_e;

  typedef struct packed {
    logic en_n;
    logic en;
    logic oe_n;
    logic we_n;
    logic drv;
  } mem_ctl_t;

  localparam mem_ctl_t CTL_QUIET = '{en_n: 1'b1, en: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

  function automatic int cycles_for(int span_ps, int clk_ps);
    int c;
    c = (span_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_cyc_fsm.sv
module sram_cyc_fsm
  import sram_cyc_pkg::*;
#(
  parameter int ACC_CYC  = 2,
  parameter int WDRV_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  output logic     ready,
  output logic     accept,
  output logic     capture,
  output mem_ctl_t ctl
);

  cyc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  mem_ctl_t         ctl_q, ctl_d;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready & req_valid;
  assign ctl    = ctl_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SETUP;
          wr_d    = req_write;
        end
      end
      ST_SETUP: begin
        if (wr_q) begin
          state_d = ST_WR_OPEN;
        end else begin
          state_d = ST_RD_ACC;
          cnt_d   = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_RD_ACC: begin
        if (cnt_q == '0) begin
          capture = 1'b1;
          state_d = ST_RECOV;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WR_OPEN: begin
        state_d = ST_WR_DRIVE;
        cnt_d   = CNT_W'(WDRV_CYC - 1);
      end
      ST_WR_DRIVE: begin
        if (cnt_q == '0) begin
          state_d = ST_RECOV;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Strobes are decoded from the next state and registered, so every
  // memory control pin comes straight from a flop.
  always_comb begin
    ctl_d = CTL_QUIET;
    case (state_d)
      ST_RD_ACC: begin
        ctl_d.en_n = 1'b0;
        ctl_d.en   = 1'b1;
        ctl_d.oe_n = 1'b0;
      end
      ST_WR_OPEN: begin
        ctl_d.en_n = 1'b0;
        ctl_d.en   = 1'b1;
        ctl_d.we_n = 1'b0;
      end
      ST_WR_DRIVE: begin
        ctl_d.en_n = 1'b0;
        ctl_d.en   = 1'b1;
        ctl_d.we_n = 1'b0;
        ctl_d.drv  = 1'b1;
      end
      default: ctl_d = CTL_QUIET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      ctl_q   <= CTL_QUIET;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      ctl_q   <= ctl_d;
    end
  end

endmodule

// File: rtl/sram_cyc_dp.sv
module sram_cyc_dp #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              rvld_q;

  // Address and write data load only on acceptance, which happens while
  // every strobe is inactive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (capture) begin
      rdat_q <= mem_dq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= capture;
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdat_q;
  assign rd_data  = rdat_q;
  assign rd_valid = rvld_q;

endmodule

// File: rtl/sram_cyc_ctrl.sv
module sram_cyc_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_ACC_PS  = 10000,
  parameter int T_WP_PS   = 8000,
  parameter int T_DSU_PS  = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int ACC_CYC  = cycles_for(T_ACC_PS, CLK_PS);
  localparam int WP_CYC   = cycles_for(T_WP_PS, CLK_PS);
  localparam int DSU_CYC  = cycles_for(T_DSU_PS, CLK_PS);
  localparam int WDRV_CYC = max3(DSU_CYC, WP_CYC - 1, 1);
  localparam int CNT_MAX  = (ACC_CYC > WDRV_CYC) ? ACC_CYC : WDRV_CYC;
  localparam int CNT_W    = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  // Reset asserts asynchronously and is released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic     accept, capture;
  mem_ctl_t ctl;

  sram_cyc_fsm #(
    .ACC_CYC (ACC_CYC),
    .WDRV_CYC(WDRV_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .req_valid(req_valid),
    .req_write(req_write),
    .ready    (req_ready),
    .accept   (accept),
    .capture  (capture),
    .ctl      (ctl)
  );

  sram_cyc_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .accept   (accept),
    .capture  (capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign mem_en_n  = ctl.en_n;
  assign mem_en    = ctl.en;
  assign mem_oe_n  = ctl.oe_n;
  assign mem_we_n  = ctl.we_n;
  assign mem_dq_oe = ctl.drv;

endmodule

// File: rtl/sram_cyc_chk.sv
module sram_cyc_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_en_n,
  input logic              mem_en,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  a_r2_strobe_under_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_en_n && mem_en));

  a_r4_drive_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  a_r4_drive_off_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

  a_r5_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_en_n && !mem_en && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_cyc_ctrl sram_cyc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rd_valid (rd_valid),
  .mem_addr (mem_addr),
  .mem_en_n (mem_en_n),
  .mem_en   (mem_en),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_cyc_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cyc_ctrl;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int CLK_PS = 8000;
  // Expected cycle counts, derived from R9 and R4.
  localparam int E_ACC  = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WP   = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int E_DSU  = (6000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WD0  = (E_DSU > E_WP - 1) ? E_DSU : E_WP - 1;
  localparam int E_WD   = (E_WD0 < 1) ? 1 : E_WD0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  sram_cyc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_en_n(mem_en_n), .mem_en(mem_en), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [DW-1:0] mem [int];
  logic          mdl_drv = 1'b0;
  logic [DW-1:0] mdl_dq  = '0;
  assign mem_dq_i = mdl_drv ? mdl_dq : (mem_dq_oe ? mem_dq_o : '0);

  int viol = 0;
  int rd_cnt = 0, last_rd_run = 0;
  int we_run = 0, drv_run = 0, last_we_run = 0, last_drv_run = 0;
  bit wr_p = 0, act_p = 0, drv_p = 0, we_low_p = 0, en_p = 0;
  logic [AW-1:0] addr_p = '0;
  logic [DW-1:0] dq_p = '0;

  function automatic logic [DW-1:0] peek(int a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  always @(negedge clk) begin
    bit en_now, wr_now, rd_now, act_now;
    en_now  = !mem_en_n && mem_en;
    wr_now  = en_now && !mem_we_n;
    rd_now  = en_now && !mem_oe_n && mem_we_n;
    act_now = !mem_en_n || mem_en || !mem_we_n;
    if (rst_n) begin
      if ((act_now || act_p) && mem_addr != addr_p) viol++;          // R6
      if (mdl_drv && mem_dq_oe) viol++;                              // R5
      if (!mem_we_n && !mem_oe_n) viol++;                            // R5
      if (mem_dq_oe && mem_we_n) viol++;                             // R4
      if (!mem_we_n && !en_p && !en_now) viol++;                     // R2
      if (en_now && en_p && !mem_we_n && !we_low_p) viol++;          // R2
      if (drv_p && mem_dq_oe && mem_dq_o != dq_p) viol++;            // R4
      if (req_ready && act_now) viol++;                              // R8
      if (wr_p && !wr_now) begin
        if (!drv_p) viol++;
        mem[int'(addr_p)] = dq_p;
      end
    end
    if (rd_now) rd_cnt = rd_cnt + 1;
    else begin
      if (rd_cnt != 0) last_rd_run = rd_cnt;
      rd_cnt = 0;
    end
    if (!mem_we_n) we_run++;
    else begin
      if (we_run != 0) begin
        last_we_run = we_run; last_drv_run = drv_run;
      end
      we_run = 0; drv_run = 0;
    end
    if (mem_dq_oe) drv_run++;
    mdl_drv = rd_now;
    mdl_dq  = (rd_cnt >= E_ACC) ? peek(int'(mem_addr)) : (peek(int'(mem_addr)) ^ 8'hEE);
    wr_p = wr_now; act_p = act_now; drv_p = mem_dq_oe; en_p = en_now;
    we_low_p = !mem_we_n; addr_p = mem_addr; dq_p = mem_dq_o;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int v0;
    v0 = viol;
    issue(1'b1, a, d);
    wait_idle();
    @(negedge clk);
    chk(peek(int'(a)) == d, "R2 stored byte", int'(peek(int'(a))), int'(d));
    chk(last_we_run == 1 + E_WD, "R4 strobe width", last_we_run, 1 + E_WD);
    chk(last_drv_run == E_WD, "R4 drive width", last_drv_run, E_WD);
    chk(viol == v0, "R5 R6 protocol during write", viol - v0, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int v0, t;
    logic [DW-1:0] got;
    v0 = viol; t = 0;
    issue(1'b0, a, '0);
    while (!rd_valid && t < 50) begin @(negedge clk); t++; end
    got = rd_data;
    chk(rd_valid && got == exp, "R3 read data", int'(got), int'(exp));
    chk(!req_ready, "R8 not ready in recovery", int'(req_ready), 0);
    @(negedge clk);
    chk(!rd_valid && rd_data == got, "R7 pulse and hold", int'(rd_valid), 0);
    chk(last_rd_run == E_ACC, "R9 access cycles", last_rd_run, E_ACC);
    chk(viol == v0, "R6 protocol during read", viol - v0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_en_n && !mem_en && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
        "R1 strobes in reset", {mem_en_n, mem_en, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && mem_en_n && !mem_en && mem_we_n && !mem_dq_oe,
        "R1 idle after reset", int'(req_ready), 1);
  endtask

  task automatic t_patterns();
    do_write(17'h00000, 8'h5A);
    do_write(17'h1FFFF, 8'hFF);
    do_write(17'h10000, 8'h00);
    do_write(17'h00001, 8'hA5);
    do_read(17'h00000, 8'h5A);
    do_read(17'h1FFFF, 8'hFF);
    do_read(17'h10000, 8'h00);
    do_read(17'h00001, 8'hA5);
  endtask

  task automatic t_walk();
    for (int i = 0; i < AW; i++) do_write(17'(1 << i), 8'(i * 13 + 1));
    for (int i = 0; i < AW; i++) do_read(17'(1 << i), 8'(i * 13 + 1));
  endtask

  task automatic t_busy_ignore();
    int v0;
    v0 = viol;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'h3C;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 17'h05555; req_wdata = 8'hC3; req_write = 1'b0;
    @(negedge clk);
    req_addr = 17'h0AAAA;
    wait_idle();
    @(negedge clk);
    chk(peek(32'h0ABCD) == 8'h3C, "R8 accepted write intact", int'(peek(32'h0ABCD)), 8'h3C);
    chk(!mem.exists(32'h05555) && !mem.exists(32'h0AAAA), "R8 busy inputs ignored",
        int'(mem.exists(32'h05555)), 0);
    chk(viol == v0, "R6 address held while busy", viol - v0, 0);
    do_read(17'h0ABCD, 8'h3C);
  endtask

  task automatic t_back_to_back();
    int v0, t;
    v0 = viol; t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00F00; req_wdata = 8'h11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addr = 17'h00F01; req_wdata = 8'h22;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b0; req_addr = 17'h00F00;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rd_valid && t < 50) begin @(negedge clk); t++; end
    chk(rd_data == 8'h11, "R3 read after back-to-back writes", int'(rd_data), 8'h11);
    chk(peek(32'h00F01) == 8'h22, "R2 second write", int'(peek(32'h00F01)), 8'h22);
    wait_idle();
    chk(viol == v0, "R5 no overlap back-to-back", viol - v0, 0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_walk();
    t_busy_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule